// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps 16-bit virtual addresses onto physical addresses through a small on-chip table of segments. The upper address bits pick one table entry. The remaining bits form an offset. The offset is bounds-checked against the entry's limit and then added to the entry's base. An entry whose valid flag is clear, or an offset outside the segment, produces an access fault instead of an address.

The table is loaded through a configuration write port that takes effect only while a privilege input is high. The kernel uses this port to install a process's segments on a context switch. Writes attempted without privilege leave the table untouched and raise a single-cycle violation pulse. Results are registered, so every translation request is answered exactly one clock later.

Top module: `seg_xlate_top`

## Requirements
- R1: The segment number is vaddr[15:14] and the offset is vaddr[13:0]. Four segments are available.
- R2: For a valid entry whose offset is below its limit, rsp_paddr equals (base + offset) modulo 2^16, and both fault flags are 0.
- R3: When offset >= limit on a valid entry, rsp_fault_range is 1, rsp_fault_invalid is 0 and rsp_paddr is 0. An offset equal to the limit counts as out of range.
- R4: When the selected entry's valid flag is 0, rsp_fault_invalid is 1, rsp_fault_range is 0 and rsp_paddr is 0, whatever the offset.
- R5: When cfg_wr_en and cfg_priv are both 1 at a clock edge, entry cfg_seg takes cfg_base, cfg_limit and cfg_valid, and requests in later cycles use the new contents.
- R6: When cfg_wr_en is 1 and cfg_priv is 0, no entry changes, and prot_violation is 1 for exactly the following cycle. At all other times prot_violation is 0.
- R7: rsp_valid is req_valid delayed by one cycle. While rsp_valid is 0, rsp_paddr and both fault flags are 0.
- R8: Reset clears every valid flag, so any request after reset and before a privileged write faults as invalid.
- R9: A request in the same cycle as a write to its own segment is translated with the entry's contents from before that write.
- R10: Loaded with the mapping {0: base 0x4000 limit 0x0800, 1: base 0x4800 limit 0x1400, 2: base 0xF000 limit 0x1000, 3: base 0x0000 limit 0x3000}, the block translates each segment according to R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault_invalid | output | 1 | Selected segment is not valid |
| rsp_fault_range | output | 1 | Offset is at or beyond the limit |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Privileged mode; writes take effect only when it is 1 |
| cfg_seg | input | 2 | Entry to write |
| cfg_base | input | 16 | Base value to load |
| cfg_limit | input | 15 | Limit value to load (segment size in bytes) |
| cfg_valid | input | 1 | Valid flag to load |
| prot_violation | output | 1 | One-cycle pulse after an unprivileged write attempt |

## Verification
A table write and a translation of the same segment can fall in the same clock edge. The bench provokes this by driving a privileged write and a request to that segment in one cycle, and then again with an unprivileged write. It expects the response computed from the bench's model as it stood before the write. On the next request it expects the new contents after a privileged write, and the unchanged contents together with a violation pulse after an unprivileged one. The surrounding sweeps step through every segment's offset range, including limit-1, limit and limit+1, with expected addresses computed arithmetically.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   // outcome of one table lookup, passed from the lookup to the response stage
   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_INVALID = 2'd1,
      FLT_RANGE   = 2'd2
   } fault_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_BITS = 2,
   parameter int BASE_W   = 16,
   parameter int LIM_W    = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_priv,
   input  logic [SEG_BITS-1:0] wr_idx,
   input  logic [BASE_W-1:0]   wr_base,
   input  logic [LIM_W-1:0]    wr_limit,
   input  logic                wr_valid,
   input  logic [SEG_BITS-1:0] rd_idx,
   output logic [BASE_W-1:0]   rd_base,
   output logic [LIM_W-1:0]    rd_limit,
   output logic                rd_valid,
   output logic                prot_pulse
);
   localparam int NSEG = 1 << SEG_BITS;

   logic [NSEG-1:0][BASE_W-1:0] base_q;
   logic [NSEG-1:0][LIM_W-1:0]  limit_q;
   logic [NSEG-1:0]             valid_q;
   logic [NSEG-1:0]             hit;
   logic                        wr_ok;
   logic                        wr_denied;

   assign wr_ok     = wr_en &  wr_priv;
   assign wr_denied = wr_en & ~wr_priv;

   // per-entry write decode
   for (genvar i = 0; i < NSEG; i++) begin : g_dec
      assign hit[i] = wr_ok && (wr_idx == SEG_BITS'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
         valid_q <= '0;
      end else begin
         for (int i = 0; i < NSEG; i++) begin
            if (hit[i]) begin
               base_q[i]  <= wr_base;
               limit_q[i] <= wr_limit;
               valid_q[i] <= wr_valid;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prot_pulse <= 1'b0;
      else        prot_pulse <= wr_denied;
   end

   // read side sees the contents before any write at this edge
   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   p_user_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_priv) |=> ($stable(base_q) && $stable(limit_q) && $stable(valid_q)));

   p_prot_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_priv) |=> prot_pulse);

   p_prot_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !wr_priv) |=> !prot_pulse);

endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W  = 14,
   parameter int BASE_W = 16,
   parameter int LIM_W  = 15
) (
   input  logic [OFF_W-1:0]  offset,
   input  logic [BASE_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   input  logic              valid,
   output logic [BASE_W-1:0] paddr,
   output fault_e            fault
);
   logic [LIM_W-1:0] off_ext;
   logic             past_end;

   assign off_ext  = LIM_W'(offset);
   assign past_end = (off_ext >= limit);    // equal to limit is outside
   assign paddr    = base + BASE_W'(offset);

   always_comb begin
      if (!valid)        fault = FLT_INVALID;
      else if (past_end) fault = FLT_RANGE;
      else               fault = FLT_NONE;
   end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
   import seg_xlate_pkg::*;
#(
   parameter int VA_W     = 16,
   parameter int SEG_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [VA_W-1:0]     req_vaddr,
   output logic                rsp_valid,
   output logic [VA_W-1:0]     rsp_paddr,
   output logic                rsp_fault_invalid,
   output logic                rsp_fault_range,
   input  logic                cfg_wr_en,
   input  logic                cfg_priv,
   input  logic [SEG_BITS-1:0] cfg_seg,
   input  logic [VA_W-1:0]     cfg_base,
   input  logic [VA_W-SEG_BITS:0] cfg_limit,
   input  logic                cfg_valid,
   output logic                prot_violation
);
   localparam int OFF_W = VA_W - SEG_BITS;
   localparam int LIM_W = OFF_W + 1;

   if (SEG_BITS < 1 || SEG_BITS >= VA_W) begin : g_bad_split
      $error("seg_xlate_top: SEG_BITS must be in 1..VA_W-1");
   end
   if (VA_W < 4) begin : g_bad_width
      $error("seg_xlate_top: VA_W too small");
   end

   logic [SEG_BITS-1:0] seg_idx;
   logic [OFF_W-1:0]    seg_off;
   logic [VA_W-1:0]     tb_base;
   logic [LIM_W-1:0]    tb_limit;
   logic                tb_valid;
   logic [VA_W-1:0]     lk_paddr;
   fault_e              lk_fault;

   assign seg_idx = req_vaddr[VA_W-1 -: SEG_BITS];
   assign seg_off = req_vaddr[OFF_W-1:0];

   seg_table #(.SEG_BITS(SEG_BITS), .BASE_W(VA_W), .LIM_W(LIM_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_priv    (cfg_priv),
      .wr_idx     (cfg_seg),
      .wr_base    (cfg_base),
      .wr_limit   (cfg_limit),
      .wr_valid   (cfg_valid),
      .rd_idx     (seg_idx),
      .rd_base    (tb_base),
      .rd_limit   (tb_limit),
      .rd_valid   (tb_valid),
      .prot_pulse (prot_violation)
   );

   seg_lookup #(.OFF_W(OFF_W), .BASE_W(VA_W), .LIM_W(LIM_W)) u_lookup (
      .offset (seg_off),
      .base   (tb_base),
      .limit  (tb_limit),
      .valid  (tb_valid),
      .paddr  (lk_paddr),
      .fault  (lk_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid         <= 1'b0;
         rsp_paddr         <= '0;
         rsp_fault_invalid <= 1'b0;
         rsp_fault_range   <= 1'b0;
      end else begin
         rsp_valid         <= req_valid;
         rsp_paddr         <= (req_valid && lk_fault == FLT_NONE) ? lk_paddr : '0;
         rsp_fault_invalid <= req_valid && (lk_fault == FLT_INVALID);
         rsp_fault_range   <= req_valid && (lk_fault == FLT_RANGE);
      end
   end

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_paddr == '0 && !rsp_fault_invalid && !rsp_fault_range));

   p_one_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_fault_invalid && rsp_fault_range));

   p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault_invalid || rsp_fault_range) |-> (rsp_paddr == '0));

endmodule

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_vaddr = '0;
   logic        rsp_valid, rsp_fault_invalid, rsp_fault_range, prot_violation;
   logic [15:0] rsp_paddr;
   logic        cfg_wr_en = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0;
   logic [1:0]  cfg_seg = '0;
   logic [15:0] cfg_base = '0;
   logic [14:0] cfg_limit = '0;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   logic [15:0] m_base  [4];
   logic [14:0] m_limit [4];
   logic        m_valid [4];

   always #5 clk = ~clk;

   seg_xlate_top u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault_invalid(rsp_fault_invalid), .rsp_fault_range(rsp_fault_range),
      .cfg_wr_en(cfg_wr_en), .cfg_priv(cfg_priv), .cfg_seg(cfg_seg),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
      .prot_violation(prot_violation)
   );

   // one cycle: optional write, optional request; checked at the next falling edge
   task automatic step(input bit wr, input bit priv, input logic [1:0] seg,
                       input logic [15:0] base, input logic [14:0] lim, input bit v,
                       input bit req, input logic [15:0] va, input string tag);
      logic [1:0]  s;
      logic [14:0] off;
      logic [15:0] e_pa;
      bit          e_fi, e_fr, e_prot;
      s = va[15:14];
      off = {1'b0, va[13:0]};
      e_pa = '0; e_fi = 0; e_fr = 0;
      if (req) begin
         if (!m_valid[s])            e_fi = 1;
         else if (off >= m_limit[s]) e_fr = 1;
         else                        e_pa = m_base[s] + 16'(off);
      end
      e_prot = wr && !priv;
      cfg_wr_en = wr; cfg_priv = priv; cfg_seg = seg;
      cfg_base = base; cfg_limit = lim; cfg_valid = v;
      req_valid = req; req_vaddr = va;
      if (wr && priv) begin
         m_base[seg] = base; m_limit[seg] = lim; m_valid[seg] = v;
      end
      @(negedge clk);
      cfg_wr_en = 0; req_valid = 0;
      n_tests++;
      if (rsp_valid !== req || rsp_paddr !== e_pa || rsp_fault_invalid !== e_fi ||
          rsp_fault_range !== e_fr || prot_violation !== e_prot) begin
         n_fail++;
         $display("FAIL %s va=%h: got v=%b pa=%h fi=%b fr=%b prot=%b exp v=%b pa=%h fi=%b fr=%b prot=%b",
                  tag, va, rsp_valid, rsp_paddr, rsp_fault_invalid, rsp_fault_range,
                  prot_violation, req, e_pa, e_fi, e_fr, e_prot);
      end
   endtask

   task automatic xl(input logic [15:0] va, input string tag);
      step(0, 0, 2'd0, 16'h0, 15'h0, 0, 1, va, tag);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run exp completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [14:0] lims [4];
      logic [15:0] bases[4];
      bases = '{16'h4000, 16'h4800, 16'hF000, 16'h0000};
      lims  = '{15'h0800, 15'h1400, 15'h1000, 15'h3000};
      for (int i = 0; i < 4; i++) begin
         m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 0;
      end
      repeat (3) @(negedge clk);
      // reset state (R7)
      n_tests++;
      if (rsp_valid !== 0 || rsp_paddr !== 0 || prot_violation !== 0 ||
          rsp_fault_invalid !== 0 || rsp_fault_range !== 0) begin
         n_fail++;
         $display("FAIL R7 reset: got v=%b pa=%h exp v=0 pa=0000", rsp_valid, rsp_paddr);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R8: all entries invalid after reset
      for (int s = 0; s < 4; s++) xl({2'(s), 14'h0123}, "R8");

      // R6: user-mode write ignored, pulse raised
      step(1, 0, 2'd0, 16'h4000, 15'h0800, 1, 0, 16'h0, "R6");
      xl(16'h0010, "R6");

      // R5 / R10: privileged load of example mapping
      for (int s = 0; s < 4; s++)
         step(1, 1, 2'(s), bases[s], lims[s], 1, 0, 16'h0, "R5");

      // R1 R2 R3 R10: sweep each segment's offsets, plus boundaries
      for (int s = 0; s < 4; s++) begin
         for (int off = 0; off < 16384; off += 499) xl({2'(s), 14'(off)}, "R10");
         xl({2'(s), 14'(lims[s] - 1)}, "R2");
         xl({2'(s), 14'(lims[s])},     "R3");
         xl({2'(s), 14'(lims[s] + 1)}, "R3");
         xl({2'(s), 14'h3FFF},         "R3");
         xl({2'(s), 14'h0000},         "R1");
      end

      // R6: user write to seg 1 leaves old mapping
      step(1, 0, 2'd1, 16'h1234, 15'h7FFF, 1, 0, 16'h0, "R6");
      xl(16'h4010, "R6");

      // R9: privileged write and request to same segment in one cycle
      step(1, 1, 2'd3, 16'h2000, 15'h0100, 1, 1, 16'hC200, "R9");
      xl(16'hC200, "R9");
      xl(16'hC0FF, "R5");

      // R9 with unprivileged write in same cycle
      step(1, 0, 2'd3, 16'h9999, 15'h7FFF, 1, 1, 16'hC200, "R9");
      xl(16'hC050, "R9");

      // R4: invalidate seg 2
      step(1, 1, 2'd2, 16'hF000, 15'h1000, 0, 0, 16'h0, "R5");
      xl(16'h8000, "R4");
      xl(16'hBFFF, "R4");

      // R7: idle cycle, then back-to-back requests
      step(0, 0, 2'd0, 16'h0, 15'h0, 0, 0, 16'h0, "R7");
      xl(16'h0000, "R7");
      xl(16'h47FF, "R7");

      // R2 wrap: base near top of space
      step(1, 1, 2'd0, 16'hFF00, 15'h4000, 1, 0, 16'h0, "R5");
      xl(16'h0200, "R2");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule